// File: doc/BRIEF.md
# Host Port Prefetching Block-Read Controller

This block serves sequential words from local memory to a host whose chip select, read strobe and write strobe are not timed to the block's clock. The host opens a read by pulling chip select and read strobe low. It waits for the ready output to rise, takes the data word, and then lets the strobes go high. The block answers with a short handshake: the data strobe drops, then ready rises, then the data strobe returns high.

Block-read mode makes sequential reads fast. The memory fetch for the following word does not wait for the next host read. It starts when the host releases the current one. The fetched word waits in a one-word buffer, so the next read is answered as soon as its strobes pass the synchronizer. With the mode off, every read fetches its word on demand. In both modes an address register, loaded by a separate strobe, supplies the fetch address and steps up by one after each completed fetch. In block-read mode, write strobe activity cancels a fetch in flight and discards the buffered word.

Top module: `hpf_blockread_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `host_rdy` is 0, `host_dstb_n` is 1 and `mem_req` is 0.
- R2: Host inputs pass through a two-flop synchronizer. When a buffered word is ready, `host_rdy` is seen high 4 clocks after the later of chip select and read strobe goes low.
- R3: `host_rdy` falls no more than 3 clocks after the earlier of chip select or read strobe returns high.
- R4: `host_rdy` stays low while only one of chip select and read strobe is low. It rises only after both have been low for the synchronizer delay.
- R5: `host_dstb_n` is low in the clock before `host_rdy` rises and in the clock where it rises. It is high again one clock later, while `host_rdy` is still high.
- R6: Successive host reads return the memory words at consecutive addresses, starting at the loaded address, in both modes.
- R7: With `blk_mode` = 1, ending a completed host read raises `mem_req` with `mem_addr` set to the address after the word just delivered, and no new host read is needed.
- R8: `addr_load` sets the next fetch address and discards any buffered word. The address register steps up by one after each completed fetch, so the first read after a load is fetched on demand.
- R9: With `blk_mode` = 0, ending a host read issues no memory request. Each read raises `mem_req` itself, so its ready comes at least 7 clocks after the strobes with a 4-clock memory.
- R10: With `blk_mode` = 1, asserting chip select and write strobe while a fetch is pending drops `mem_req` and leaves the address unchanged. The next host read then returns the word whose fetch was abandoned.
- R11: With `blk_mode` = 1, write strobe activity discards a valid buffered word. The next read is fetched on demand from the address register, which is the word after the discarded one.
- R12: While `mem_req` is high, `mem_addr` is stable, and the request stays up until `mem_ack` or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_mode | input | 1 | 1 = prefetch on read release, 0 = fetch on demand |
| addr_load | input | 1 | One-clock strobe that loads the fetch address |
| addr_in | input | AW | Address loaded by `addr_load` |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_rdy | output | 1 | Ready to the host, high when data is valid |
| host_dstb_n | output | 1 | Data strobe to the host, active low |
| host_data | output | DW | Word returned to the host |
| mem_req | output | 1 | Memory read request, held until acknowledge |
| mem_addr | output | AW | Memory read address |
| mem_ack | input | 1 | One-clock acknowledge with read data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
The assertions about strobe timing assume that host inputs change only between clock edges and keep each level for several clocks. Under that assumption, counting clocks through the two synchronizer flops is meaningful. The bench changes every host strobe on the falling clock edge and holds each level for at least three clocks. The memory model raises `mem_ack` only while `mem_req` is high and clears it one clock later. This matches the acknowledge pulse that the request-hold assertion expects. A cancelling write is driven only while the read strobe is high, so the host never reads and writes at the same time.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  // host handshake sequence, one step per clock
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,  // waiting for a read with buffered data
    HS_STB  = 2'd1,  // data strobe low, ready still low
    HS_RDY  = 2'd2,  // ready high, data strobe low
    HS_HOLD = 2'd3   // ready high, data strobe released
  } hs_state_e;
endpackage

// File: rtl/hpf_sync.sv
module hpf_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  // inactive-high strobes: reset to ones
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[b] <= 1'b1;
        stage2[b] <= 1'b1;
      end else begin
        stage1[b] <= d_async[b];
        stage2[b] <= stage1[b];
      end
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/hpf_host_seq.sv
module hpf_host_seq
  import hpf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act,
  input  logic          buf_vld,
  input  logic [DW-1:0] buf_word,
  output logic          rdy,
  output logic          dstb_n,
  output logic [DW-1:0] data,
  output logic          want,
  output logic          done
);
  hs_state_e st;

  // a read that has reached ready and is now released is consumed
  assign done = !rd_act && (st == HS_RDY || st == HS_HOLD);
  // a read waiting in idle with nothing buffered asks for a fetch
  assign want = rd_act && (st == HS_IDLE) && !buf_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= HS_IDLE;
      rdy    <= 1'b0;
      dstb_n <= 1'b1;
      data   <= '0;
    end else begin
      case (st)
        HS_IDLE: begin
          if (rd_act && buf_vld) begin
            st     <= HS_STB;
            dstb_n <= 1'b0;
            data   <= buf_word;
          end
        end
        HS_STB: begin
          if (!rd_act) begin
            st     <= HS_IDLE;
            dstb_n <= 1'b1;
          end else begin
            st  <= HS_RDY;
            rdy <= 1'b1;
          end
        end
        HS_RDY: begin
          dstb_n <= 1'b1;
          if (!rd_act) begin
            st  <= HS_IDLE;
            rdy <= 1'b0;
          end else begin
            st <= HS_HOLD;
          end
        end
        default: begin
          if (!rd_act) begin
            st  <= HS_IDLE;
            rdy <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hpf_fetch.sv
module hpf_fetch #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_mode,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          want,
  input  logic          done,
  input  logic          wr_act,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          buf_vld,
  output logic [DW-1:0] buf_word
);
  localparam logic [AW-1:0] ADDR_STEP = AW'(1);

  logic [AW-1:0] addr_q;
  logic          pend_q;
  logic          vld_q;
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else if (addr_load) begin
      addr_q <= addr_in;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (blk_mode && wr_act) begin
      // cancel fetch in flight and drop buffered word
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (pend_q && mem_ack) begin
      word_q <= mem_rdata;
      vld_q  <= 1'b1;
      pend_q <= 1'b0;
      addr_q <= addr_q + ADDR_STEP;
    end else if (done) begin
      vld_q <= 1'b0;
      if (blk_mode) pend_q <= 1'b1;
    end else if (want && !vld_q && !pend_q) begin
      pend_q <= 1'b1;
    end
  end

  assign mem_req  = pend_q;
  assign mem_addr = addr_q;
  assign buf_vld  = vld_q;
  assign buf_word = word_q;
endmodule

// File: rtl/hpf_blockread_ctrl.sv
module hpf_blockread_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blk_mode,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  output logic          host_rdy,
  output logic          host_dstb_n,
  output logic [DW-1:0] host_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int NSTROBE = 3;

  logic [NSTROBE-1:0] strb_s;
  logic               rd_act;
  logic               wr_act;
  logic               want;
  logic               done;
  logic               buf_vld;
  logic [DW-1:0]      buf_word;

  hpf_sync #(.W(NSTROBE)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({host_wr_n, host_rd_n, host_cs_n}),
    .d_sync  (strb_s)
  );

  assign rd_act = !strb_s[0] && !strb_s[1];
  assign wr_act = !strb_s[0] && !strb_s[2];

  hpf_host_seq #(.DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rd_act   (rd_act),
    .buf_vld  (buf_vld),
    .buf_word (buf_word),
    .rdy      (host_rdy),
    .dstb_n   (host_dstb_n),
    .data     (host_data),
    .want     (want),
    .done     (done)
  );

  hpf_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .blk_mode  (blk_mode),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .want      (want),
    .done      (done),
    .wr_act    (wr_act),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .buf_vld   (buf_vld),
    .buf_word  (buf_word)
  );
endmodule

// File: rtl/hpf_blockread_chk.sv
module hpf_blockread_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          host_cs_n,
  input logic          host_rd_n,
  input logic          host_rdy,
  input logic          host_dstb_n,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!host_rdy && host_dstb_n && !mem_req));

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((host_rd_n && $past(host_rd_n) && $past(host_rd_n, 2)) ||
     (host_cs_n && $past(host_cs_n) && $past(host_cs_n, 2))) |=> !host_rdy);

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rdy) |-> ($past(!host_rd_n, 3) && $past(!host_cs_n, 3)));

  // R5
  dstb_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rdy) |-> (!host_dstb_n && $past(!host_dstb_n)));

  // R5
  dstb_release_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rdy && $past(host_rdy)) |-> host_dstb_n);

  // R12
  req_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));
endmodule

bind hpf_blockread_ctrl hpf_blockread_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_cs_n   (host_cs_n),
  .host_rd_n   (host_rd_n),
  .host_rdy    (host_rdy),
  .host_dstb_n (host_dstb_n),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr)
);

// File: tb/tb_hpf_blockread_ctrl.sv
`timescale 1ns/1ps
module tb_hpf_blockread_ctrl;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          blk_mode = 1'b0;
  logic          addr_load = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          host_cs_n = 1'b1;
  logic          host_rd_n = 1'b1;
  logic          host_wr_n = 1'b1;
  logic          host_rdy;
  logic          host_dstb_n;
  logic [DW-1:0] host_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  hpf_blockread_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .blk_mode(blk_mode), .addr_load(addr_load),
    .addr_in(addr_in), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_rdy(host_rdy), .host_dstb_n(host_dstb_n),
    .host_data(host_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return {16'h0, a} * 32'd7 + 32'h100;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: acknowledge LAT clocks after a request is seen
  int            mcnt = 0;
  logic [AW-1:0] req_addr = '0;
  always @(negedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mcnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      mcnt = 0;
    end else if (mem_req) begin
      if (mcnt == 0) req_addr = mem_addr;
      if (mcnt == LAT - 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= word_at(mem_addr);
        // R12 address held for the whole request
        check(mem_addr == req_addr, "R12", mem_addr, req_addr);
      end else begin
        mcnt++;
      end
    end else begin
      mcnt = 0;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    addr_in = a;
    addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  // full host read; returns data and clocks until ready
  task automatic host_read(output logic [DW-1:0] d, output int lat);
    host_cs_n = 1'b0;
    host_rd_n = 1'b0;
    lat = 0;
    d = '0;
    while (!host_rdy && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check(host_rdy, "R6 read timeout", host_rdy, 1);
    // R5 data strobe low when ready first seen
    check(!host_dstb_n, "R5 dstb low at ready", host_dstb_n, 0);
    d = host_data;
    @(negedge clk);
    check(host_dstb_n && host_rdy, "R5 dstb release", {host_dstb_n, host_rdy}, 3);
    host_rd_n = 1'b1;
    host_cs_n = 1'b1;
    ticks(3);
    // R3 ready low within 3 clocks of release
    check(!host_rdy, "R3 ready drop", host_rdy, 0);
  endtask

  logic [DW-1:0] d;
  int lat;

  initial begin
    ticks(4);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!host_rdy && host_dstb_n && !mem_req, "R1 reset state",
          {host_rdy, host_dstb_n, mem_req}, 3'b010);

    // block mode sweep
    blk_mode = 1'b1;
    load_addr(16'd100);
    for (int i = 0; i < 8; i++) begin
      host_read(d, lat);
      check(d == word_at(16'(100 + i)), "R6 block data", d, word_at(16'(100 + i)));
      if (i == 0) check(lat >= 7, "R8 first read after load on demand", lat, 7);
      else        check(lat == 4, "R2 buffered latency", lat, 4);
      for (int k = 0; k < 8 && !mem_req; k++) @(negedge clk);
      check(mem_req && mem_addr == 16'(101 + i), "R7 prefetch address",
            mem_addr, 101 + i);
      ticks(10);
    end

    // on-demand mode
    blk_mode = 1'b0;
    load_addr(16'd300);
    for (int i = 0; i < 4; i++) begin
      host_read(d, lat);
      check(d == word_at(16'(300 + i)), "R6 demand data", d, word_at(16'(300 + i)));
      check(lat >= 7, "R9 demand latency", lat, 7);
      begin
        bit seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
          if (mem_req) seen = 1'b1;
          @(negedge clk);
        end
        check(!seen, "R9 no prefetch on release", seen, 0);
      end
    end

    // R10 abort of a pending prefetch
    blk_mode = 1'b1;
    load_addr(16'd500);
    host_read(d, lat);
    check(d == word_at(16'd500), "R6 data", d, word_at(16'd500));
    host_cs_n = 1'b0;
    host_wr_n = 1'b0;
    ticks(4);
    check(!mem_req, "R10 request dropped", mem_req, 0);
    host_wr_n = 1'b1;
    host_cs_n = 1'b1;
    ticks(8);
    check(!mem_req, "R10 no reissue", mem_req, 0);
    host_read(d, lat);
    check(d == word_at(16'd501), "R10 abandoned word refetched", d, word_at(16'd501));
    check(lat >= 7, "R10 refetch on demand", lat, 7);

    // R11 discard a valid buffered word (502 buffered, address now 503)
    ticks(12);
    host_cs_n = 1'b0;
    host_wr_n = 1'b0;
    ticks(4);
    host_wr_n = 1'b1;
    host_cs_n = 1'b1;
    ticks(6);
    host_read(d, lat);
    check(lat >= 7, "R11 buffer discarded", lat, 7);
    check(d == word_at(16'd503), "R11 next word", d, word_at(16'd503));

    // R4 later of the two strobes (504 buffered)
    ticks(12);
    host_rd_n = 1'b0;
    ticks(10);
    check(!host_rdy, "R4 ready low with read strobe only", host_rdy, 0);
    host_cs_n = 1'b0;
    lat = 0;
    while (!host_rdy && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 4, "R4 ready after later strobe", lat, 4);
    check(host_data == word_at(16'd504), "R6 data", host_data, word_at(16'd504));
    ticks(2);
    // R3 earlier strobe: chip select alone ends the transfer
    host_cs_n = 1'b1;
    ticks(3);
    check(!host_rdy, "R3 ready drop on chip select", host_rdy, 0);
    host_rd_n = 1'b1;

    // R8 load while a word is buffered (505)
    ticks(12);
    load_addr(16'd700);
    ticks(2);
    host_read(d, lat);
    check(d == word_at(16'd700), "R8 load discards buffer", d, word_at(16'd700));
    check(lat >= 7, "R8 on-demand after load", lat, 7);

    ticks(4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule